// File: doc/BRIEF.md
# SATA Link Frame Transmitter

This block is the transmit half of a SATA link layer. Once the physical layer reports a usable link, the block waits in idle and sends continuous SYNC primitives. When the transport side asks to send a prepared frame, the block announces it with X_RDY and keeps announcing it until the device answers with R_RDY. It then sends SOF, the payload dwords taken from a transmit FIFO, a CRC dword and EOF. Finally it sends WTRM until the device reports the frame status.

Payload dwords come from an external first-word-fall-through FIFO. That FIFO shows its head dword, an empty flag, a fill level and a flag that marks the head as the frame's last dword. If the FIFO runs dry in the middle of a frame, the block sends HOLD primitives. It resumes only when the FIFO holds enough dwords to restart without running dry again at once. Scrambling, 8b/10b encoding and FIS construction belong to other blocks.

Every output dword comes with a flag that tells a primitive apart from a data dword. Received traffic arrives the same way, as a dword with its own primitive flag.

Top module: `sata_frame_tx`

## Requirements
- R1: After reset, and whenever `link_up` is low, the block drives SYNC (0xB5B5957C, `tx_is_prim`=1) and keeps `fifo_rd`, `done` and `err` low. While the link is down, `send_req` has no effect.
- R2: In idle with `link_up` high, a `send_req` causes X_RDY (0x5757B57C, flag 1) to be sent on every cycle. This continues until R_RDY (`rx_dword`=0x4A4A957C with `rx_is_prim`=1) is received.
- R3: The cycle after R_RDY is seen, SOF (0x3737B57C, flag 1) is sent. Next come the FIFO dwords in FIFO order with flag 0. Each dword is sent in the cycle after the edge at which `fifo_rd` pops it. The dword popped while `fifo_last` is high ends the payload.
- R4: The dword after the final payload dword is the CRC, with flag 0. The CRC uses polynomial 0x04C11DB7 and seed 0x52325032, with no reflection and no final inversion. It is computed over all payload dwords in order, most significant bit first.
- R5: EOF (0xD5D5B57C, flag 1) follows the CRC. After EOF, WTRM (0x5858B57C, flag 1) is sent on every cycle until R_OK or R_ERR is received.
- R6: If the FIFO is empty before the final payload dword, HOLD (0xD5D5AA7C, flag 1) is sent and nothing is read. Once holding, data resumes only when `fifo_level` is at least `RESUME_LVL`. `fifo_rd` is never high while `fifo_empty` is high.
- R7: Receiving R_OK (0x3535B57C) while in WTRM raises `done` for exactly one cycle, and the block returns to idle, sending SYNC.
- R8: Receiving R_ERR (0x5656B57C) while in WTRM raises `err` for one cycle with `done` low, and the block returns to idle. `done` and `err` are never high together.
- R9: If `link_up` falls while a frame is in progress (from X_RDY through WTRM), the frame is abandoned: `err` pulses for one cycle, SYNC is sent, and the block waits inactive for the link to return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Physical link ready |
| send_req | input | 1 | Request to transmit the prepared frame |
| fifo_data | input | 32 | Head dword of the transmit FIFO |
| fifo_empty | input | 1 | Transmit FIFO is empty |
| fifo_level | input | LVL_W | Number of dwords in the transmit FIFO |
| fifo_last | input | 1 | Head dword is the final payload dword |
| rx_dword | input | 32 | Received dword from the device |
| rx_is_prim | input | 1 | Received dword is a primitive |
| tx_dword | output | 32 | Transmit dword |
| tx_is_prim | output | 1 | Transmit dword is a primitive |
| fifo_rd | output | 1 | Pop the FIFO head this cycle |
| done | output | 1 | One-cycle pulse: frame accepted by device |
| err | output | 1 | One-cycle pulse: frame rejected or aborted |

## Verification
The bench delays R_RDY by several cycles to confirm that SOF waits for the handshake. A design that starts on request alone would put SOF in the stream too early. It then starves the FIFO partway through a frame and refills it one dword at a time, stopping one short of the resume level. A design that resumed on any non-empty FIFO would send data while HOLD is expected, and one that read an empty FIFO would emit a stale dword. Frames ending in R_ERR, and a link drop during X_RDY, check that `err` pulses alone and that the stream falls back to SYNC. Every payload is compared against a CRC computed in the bench, so a wrong seed, a wrong bit order or a missed dword shows up as a mismatched CRC.

// File: rtl/sata_ftx_pkg.sv
package sata_ftx_pkg;

    localparam logic [31:0] PRIM_SYNC  = 32'hB5B5957C;
    localparam logic [31:0] PRIM_XRDY  = 32'h5757B57C;
    localparam logic [31:0] PRIM_RRDY  = 32'h4A4A957C;
    localparam logic [31:0] PRIM_SOF   = 32'h3737B57C;
    localparam logic [31:0] PRIM_EOF   = 32'hD5D5B57C;
    localparam logic [31:0] PRIM_HOLD  = 32'hD5D5AA7C;
    localparam logic [31:0] PRIM_WTRM  = 32'h5858B57C;
    localparam logic [31:0] PRIM_ROK   = 32'h3535B57C;
    localparam logic [31:0] PRIM_RERR  = 32'h5656B57C;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED = 32'h52325032;

    typedef enum logic [2:0] {
        ST_DOWN,
        ST_IDLE,
        ST_XRDY,
        ST_DATA,
        ST_CRC,
        ST_EOF,
        ST_WTRM
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_OTHER,
        RX_RRDY,
        RX_ROK,
        RX_RERR
    } rx_kind_e;

    typedef struct packed {
        logic        is_prim;
        logic [31:0] dword;
    } link_word_t;

    function automatic link_word_t prim_word(input logic [31:0] code);
        link_word_t w;
        w.is_prim = 1'b1;
        w.dword   = code;
        return w;
    endfunction

    function automatic link_word_t data_word(input logic [31:0] value);
        link_word_t w;
        w.is_prim = 1'b0;
        w.dword   = value;
        return w;
    endfunction

    // One dword through the CRC, most significant bit first.
    function automatic logic [31:0] crc32_dword(input logic [31:0] crc_in,
                                                input logic [31:0] data);
        logic [31:0] c;
        c = crc_in;
        for (int i = 31; i >= 0; i--) begin
            if (c[31] ^ data[i]) c = (c << 1) ^ CRC_POLY;
            else                 c = c << 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/sata_ftx_rxdec.sv
module sata_ftx_rxdec
    import sata_ftx_pkg::*;
(
    input  logic [31:0] rx_dword,
    input  logic        rx_is_prim,
    output rx_kind_e    rx_kind
);

    always_comb begin
        rx_kind = RX_OTHER;
        if (rx_is_prim) begin
            unique case (rx_dword)
                PRIM_RRDY: rx_kind = RX_RRDY;
                PRIM_ROK:  rx_kind = RX_ROK;
                PRIM_RERR: rx_kind = RX_RERR;
                default:   rx_kind = RX_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sata_ftx_crc.sv
module sata_ftx_crc
    import sata_ftx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        en,
    input  logic [31:0] din,
    output logic [31:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || init) crc <= CRC_SEED;
        else if (en)     crc <= crc32_dword(crc, din);
    end

endmodule

// File: rtl/sata_ftx_flow.sv
module sata_ftx_flow #(
    parameter int LVL_W      = 5,
    parameter int RESUME_LVL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_data,
    input  logic             fifo_empty,
    input  logic [LVL_W-1:0] fifo_level,
    output logic             can_send
);

    localparam logic [LVL_W-1:0] RESUME_AT = LVL_W'(RESUME_LVL);

    logic holding;
    logic enough;

    assign enough   = (fifo_level >= RESUME_AT);
    assign can_send = !fifo_empty && (!holding || enough);

    // Set on an underrun inside the payload, cleared once the FIFO has refilled.
    always_ff @(posedge clk) begin
        if (rst || !in_data) holding <= 1'b0;
        else                 holding <= !can_send;
    end

endmodule

// File: rtl/sata_ftx_fsm.sv
module sata_ftx_fsm
    import sata_ftx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        link_up,
    input  logic        send_req,
    input  rx_kind_e    rx_kind,
    input  logic        can_send,
    input  logic        fifo_last,
    input  logic [31:0] fifo_data,
    input  logic [31:0] crc_val,
    output link_word_t  tx_word,
    output logic        fifo_rd,
    output logic        crc_init,
    output logic        in_data,
    output logic        done,
    output logic        err
);

    tx_state_e state;
    logic      in_frame;

    assign in_data  = (state == ST_DATA);
    assign in_frame = (state != ST_DOWN) && (state != ST_IDLE);
    assign fifo_rd  = link_up && in_data && can_send;
    assign crc_init = link_up && (state == ST_XRDY) && (rx_kind == RX_RRDY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_DOWN;
            tx_word <= prim_word(PRIM_SYNC);
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (!link_up) begin
                state   <= ST_DOWN;
                tx_word <= prim_word(PRIM_SYNC);
                err     <= in_frame;
            end else begin
                unique case (state)
                    ST_DOWN: begin
                        tx_word <= prim_word(PRIM_SYNC);
                        state   <= ST_IDLE;
                    end
                    ST_IDLE: begin
                        if (send_req) begin
                            tx_word <= prim_word(PRIM_XRDY);
                            state   <= ST_XRDY;
                        end else begin
                            tx_word <= prim_word(PRIM_SYNC);
                        end
                    end
                    ST_XRDY: begin
                        if (rx_kind == RX_RRDY) begin
                            tx_word <= prim_word(PRIM_SOF);
                            state   <= ST_DATA;
                        end else begin
                            tx_word <= prim_word(PRIM_XRDY);
                        end
                    end
                    ST_DATA: begin
                        if (can_send) begin
                            tx_word <= data_word(fifo_data);
                            if (fifo_last) state <= ST_CRC;
                        end else begin
                            tx_word <= prim_word(PRIM_HOLD);
                        end
                    end
                    ST_CRC: begin
                        tx_word <= data_word(crc_val);
                        state   <= ST_EOF;
                    end
                    ST_EOF: begin
                        tx_word <= prim_word(PRIM_EOF);
                        state   <= ST_WTRM;
                    end
                    ST_WTRM: begin
                        if (rx_kind == RX_ROK) begin
                            tx_word <= prim_word(PRIM_SYNC);
                            done    <= 1'b1;
                            state   <= ST_IDLE;
                        end else if (rx_kind == RX_RERR) begin
                            tx_word <= prim_word(PRIM_SYNC);
                            err     <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            tx_word <= prim_word(PRIM_WTRM);
                        end
                    end
                    default: begin
                        tx_word <= prim_word(PRIM_SYNC);
                        state   <= ST_DOWN;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/sata_frame_tx.sv
module sata_frame_tx
    import sata_ftx_pkg::*;
#(
    parameter int LVL_W      = 5,
    parameter int RESUME_LVL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             link_up,
    input  logic             send_req,
    input  logic [31:0]      fifo_data,
    input  logic             fifo_empty,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             fifo_last,
    input  logic [31:0]      rx_dword,
    input  logic             rx_is_prim,
    output logic [31:0]      tx_dword,
    output logic             tx_is_prim,
    output logic             fifo_rd,
    output logic             done,
    output logic             err
);

    rx_kind_e   rx_kind;
    logic       can_send;
    logic       in_data;
    logic       crc_init;
    logic [31:0] crc_val;
    link_word_t tx_word;

    sata_ftx_rxdec u_rxdec (
        .rx_dword   (rx_dword),
        .rx_is_prim (rx_is_prim),
        .rx_kind    (rx_kind)
    );

    sata_ftx_flow #(
        .LVL_W      (LVL_W),
        .RESUME_LVL (RESUME_LVL)
    ) u_flow (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .fifo_empty (fifo_empty),
        .fifo_level (fifo_level),
        .can_send   (can_send)
    );

    sata_ftx_crc u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (crc_init),
        .en   (fifo_rd),
        .din  (fifo_data),
        .crc  (crc_val)
    );

    sata_ftx_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .link_up   (link_up),
        .send_req  (send_req),
        .rx_kind   (rx_kind),
        .can_send  (can_send),
        .fifo_last (fifo_last),
        .fifo_data (fifo_data),
        .crc_val   (crc_val),
        .tx_word   (tx_word),
        .fifo_rd   (fifo_rd),
        .crc_init  (crc_init),
        .in_data   (in_data),
        .done      (done),
        .err       (err)
    );

    assign tx_dword   = tx_word.dword;
    assign tx_is_prim = tx_word.is_prim;

endmodule

// File: rtl/sata_frame_tx_chk.sv
module sata_frame_tx_chk
    import sata_ftx_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        link_up,
    input logic [31:0] rx_dword,
    input logic        rx_is_prim,
    input logic        fifo_empty,
    input logic        fifo_rd,
    input logic [31:0] tx_dword,
    input logic        tx_is_prim,
    input logic        done,
    input logic        err
);

    assert_sync_when_down_R1: assert property (@(posedge clk) disable iff (rst)
        !link_up |=> (tx_is_prim && tx_dword == PRIM_SYNC && !fifo_rd));

    assert_no_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

    assert_read_emits_data_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> !tx_is_prim);

    assert_done_after_rok_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(rx_is_prim && rx_dword == PRIM_ROK));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

endmodule

bind sata_frame_tx sata_frame_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_up    (link_up),
    .rx_dword   (rx_dword),
    .rx_is_prim (rx_is_prim),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .tx_dword   (tx_dword),
    .tx_is_prim (tx_is_prim),
    .done       (done),
    .err        (err)
);

// File: tb/sata_frame_tx_tb.sv
module sata_frame_tx_tb;

    localparam int LVL_W      = 5;
    localparam int RESUME_LVL = 4;

    localparam logic [31:0] K_SYNC = 32'hB5B5957C;
    localparam logic [31:0] K_XRDY = 32'h5757B57C;
    localparam logic [31:0] K_RRDY = 32'h4A4A957C;
    localparam logic [31:0] K_SOF  = 32'h3737B57C;
    localparam logic [31:0] K_EOF  = 32'hD5D5B57C;
    localparam logic [31:0] K_HOLD = 32'hD5D5AA7C;
    localparam logic [31:0] K_WTRM = 32'h5858B57C;
    localparam logic [31:0] K_ROK  = 32'h3535B57C;
    localparam logic [31:0] K_RERR = 32'h5656B57C;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             link_up = 1'b0;
    logic             send_req = 1'b0;
    logic [31:0]      fifo_data = '0;
    logic             fifo_empty = 1'b1;
    logic [LVL_W-1:0] fifo_level = '0;
    logic             fifo_last = 1'b0;
    logic [31:0]      rx_dword = K_SYNC;
    logic             rx_is_prim = 1'b1;
    logic [31:0]      tx_dword;
    logic             tx_is_prim;
    logic             fifo_rd;
    logic             done;
    logic             err;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sata_frame_tx #(.LVL_W(LVL_W), .RESUME_LVL(RESUME_LVL)) u_dut (
        .clk(clk), .rst(rst), .link_up(link_up), .send_req(send_req),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_level(fifo_level),
        .fifo_last(fifo_last), .rx_dword(rx_dword), .rx_is_prim(rx_is_prim),
        .tx_dword(tx_dword), .tx_is_prim(tx_is_prim), .fifo_rd(fifo_rd),
        .done(done), .err(err)
    );

    // ---------------- transmit FIFO model ----------------
    logic [31:0] q_data[$];
    bit          q_last[$];
    logic        push_v = 1'b0;
    logic [31:0] push_d = '0;
    logic        push_l = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            q_data.delete();
            q_last.delete();
        end else begin
            if (fifo_rd && q_data.size() > 0) begin
                void'(q_data.pop_front());
                void'(q_last.pop_front());
            end
            if (push_v) begin
                q_data.push_back(push_d);
                q_last.push_back(push_l);
            end
        end
        fifo_empty <= (q_data.size() == 0);
        fifo_level <= LVL_W'(q_data.size());
        fifo_data  <= (q_data.size() > 0) ? q_data[0] : 32'h0;
        fifo_last  <= (q_last.size() > 0) ? q_last[0] : 1'b0;
    end

    // ---------------- scoreboard ----------------
    logic [32:0] exp_q[$];
    string       tag_q[$];
    logic [32:0] last_obs = {1'b1, K_SYNC};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic exp_push(input bit p, input logic [31:0] w, input string tag);
        exp_q.push_back({p, w});
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin
        logic [32:0] obs;
        obs = {tx_is_prim, tx_dword};
        if (!rst && !finished) begin
            if (obs == {1'b1, K_SYNC}) begin
            end else if (tx_is_prim && obs == last_obs) begin
            end else if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected tx word", obs, 33'h0);
            end else begin
                logic [32:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(obs == e, t, "tx stream", obs, e);
            end
        end
        last_obs = obs;
    end

    // ---------------- reference CRC ----------------
    function automatic logic [31:0] ref_crc(input logic [31:0] seed,
                                            input logic [31:0] d);
        logic [31:0] r;
        r = seed;
        for (int k = 0; k < 32; k++) begin
            logic fb;
            fb = r[31] ^ d[31-k];
            r = {r[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
        end
        return r;
    endfunction

    // ---------------- driver ----------------
    logic [31:0] words[8];

    task automatic push_word(input logic [31:0] d, input bit l);
        push_v = 1'b1; push_d = d; push_l = l;
        @(negedge clk);
        push_v = 1'b0;
    endtask

    task automatic wait_tx(input logic [31:0] w);
        do @(negedge clk); while (!(tx_is_prim && tx_dword == w));
    endtask

    task automatic run_frame(input int n, input int preload, input logic [31:0] base,
                             input int rrdy_delay, input bit reject);
        logic [31:0] c;
        c = 32'h52325032;
        for (int i = 0; i < n; i++) words[i] = base + 32'h0101_0111 * i;
        exp_push(1'b1, K_XRDY, "R2");
        exp_push(1'b1, K_SOF, "R3");
        for (int i = 0; i < n; i++) begin
            if (i == preload && preload < n) exp_push(1'b1, K_HOLD, "R6");
            exp_push(1'b0, words[i], "R3");
            c = ref_crc(c, words[i]);
        end
        exp_push(1'b0, c, "R4");
        exp_push(1'b1, K_EOF, "R5");
        exp_push(1'b1, K_WTRM, "R5");
        for (int i = 0; i < preload; i++) push_word(words[i], i == n - 1);
        send_req = 1'b1;
        wait_tx(K_XRDY);
        send_req = 1'b0;
        repeat (rrdy_delay) @(negedge clk);
        rx_dword = K_RRDY; rx_is_prim = 1'b1;
        wait_tx(K_SOF);
        rx_dword = K_SYNC;
        if (preload < n) begin
            wait_tx(K_HOLD);
            repeat (3) @(negedge clk);
            for (int i = preload; i < n - 1; i++) push_word(words[i], 1'b0);
            repeat (4) @(negedge clk);
            // R6: level below the resume point, must keep holding
            check(tx_is_prim && tx_dword == K_HOLD, "R6", "hold below resume level",
                  {tx_is_prim, tx_dword}, {1'b1, K_HOLD});
            check(q_data.size() == n - 1 - preload, "R6", "no read while holding",
                  33'(q_data.size()), 33'(n - 1 - preload));
            push_word(words[n-1], 1'b1);
        end
        wait_tx(K_WTRM);
        rx_dword = reject ? K_RERR : K_ROK;
        @(negedge clk);
        rx_dword = K_SYNC;
        if (reject) begin
            check(err == 1'b1 && done == 1'b0, "R8", "err pulse on R_ERR",
                  {31'h0, done, err}, 33'h1);
        end else begin
            check(done == 1'b1 && err == 1'b0, "R7", "done pulse on R_OK",
                  {31'h0, done, err}, 33'h2);
        end
        check(tx_is_prim && tx_dword == K_SYNC, reject ? "R8" : "R7", "back to idle SYNC",
              {tx_is_prim, tx_dword}, {1'b1, K_SYNC});
        @(negedge clk);
        check(!done && !err, "R7", "status is a single pulse",
              {31'h0, done, err}, 33'h0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(tx_is_prim && tx_dword == K_SYNC && !fifo_rd && !done && !err, "R1",
              "reset state", {tx_is_prim, tx_dword}, {1'b1, K_SYNC});
        rst = 1'b0;
        // R1: request ignored while the link is down
        send_req = 1'b1;
        repeat (6) @(negedge clk);
        check(tx_is_prim && tx_dword == K_SYNC, "R1", "req ignored with link down",
              {tx_is_prim, tx_dword}, {1'b1, K_SYNC});
        send_req = 1'b0;
        link_up = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_is_prim && tx_dword == K_SYNC, "R1", "idle sends SYNC",
              {tx_is_prim, tx_dword}, {1'b1, K_SYNC});

        // R2/R3/R4/R5/R7: preloaded frame, delayed R_RDY
        run_frame(3, 3, 32'hA000_0001, 4, 1'b0);
        // R8: single-dword frame rejected
        run_frame(1, 1, 32'h5EED_0F00, 1, 1'b1);
        // R6: underrun mid-frame
        run_frame(6, 2, 32'h1234_5670, 0, 1'b0);

        // R9: link drop during X_RDY
        exp_push(1'b1, K_XRDY, "R9");
        send_req = 1'b1;
        wait_tx(K_XRDY);
        send_req = 1'b0;
        repeat (2) @(negedge clk);
        link_up = 1'b0;
        @(negedge clk);
        check(err == 1'b1 && done == 1'b0, "R9", "abort flags err",
              {31'h0, done, err}, 33'h1);
        check(tx_is_prim && tx_dword == K_SYNC, "R9", "abort sends SYNC",
              {tx_is_prim, tx_dword}, {1'b1, K_SYNC});
        send_req = 1'b1;
        repeat (4) @(negedge clk);
        check(tx_is_prim && tx_dword == K_SYNC && !err, "R9", "inactive until link returns",
              {tx_is_prim, tx_dword}, {1'b1, K_SYNC});
        send_req = 1'b0;
        link_up = 1'b1;
        repeat (3) @(negedge clk);

        // recovery frame after abort
        run_frame(2, 2, 32'hC0DE_0010, 2, 1'b0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3", "all expected words seen",
              33'(exp_q.size()), 33'h0);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired: actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule